// File: doc/BRIEF.md
# FM Synthesizer Interval Timer and Status Unit

This unit gives a host two 8-bit interval timers with fixed, different tick rates, a shared control register, a status byte and an interrupt line. The fast timer advances once per base tick, which a prescaler derives from the system clock (`TICK_CYCLES` clocks, standing for 80 µs). The slow timer advances on every fourth base tick (`SLOW_DIV`, standing for 320 µs). A timer counts up from its preload value. When it wraps past 0xFF it reloads and keeps going for as long as its start bit stays set. A wrap latches that timer's overflow flag in the status byte, unless the timer is masked.

The host writes in two steps. It first writes a register index through the index port (`bus_port` = 0), then writes the value through the data port (`bus_port` = 1). Status is always presented on `status_o`, which is what the index port returns when read. The control register has a write-only interrupt-reset command that clears every latched flag and leaves the start and mask settings untouched. Software can therefore acknowledge an interrupt without restarting its timers. All pins are plain control and status signals, because no data stream passes through the unit.

Top module: `fmtmr_unit`

## Requirements
- R1: After reset, `status_o` reads 0x06 (bits 7..5 = 000, bits 4..0 = `ID_CODE`, default 0x06) and `irq_o` is low.
- R2: A write with `bus_port`=0 loads the index. A write with `bus_port`=1 stores the data into the indexed register: 0x02 holds the fast preload, 0x03 holds the slow preload and 0x04 holds control. A data write at any other index changes nothing.
- R3: With fast preload p, and counting N = 256 − p, the fast flag (status bit 6) first reads 1 between (N−1)·T+1 and N·T clocks after the clock edge that sets the start bit. Here T = `TICK_CYCLES`.
- R4: With slow preload p, the slow flag (status bit 5) first reads 1 between (N−1)·4T+1 and N·4T clocks after the edge that sets its start bit.
- R5: A started timer reloads on overflow and keeps running, so its successive overflows are exactly N·T clocks apart for the fast timer.
- R6: While a timer's mask bit is set (control bit 6 fast, bit 5 slow), its flag never becomes set, even though the timer is running.
- R7: A control write with bit 7 set clears status bits 7..5 on the next clock. It leaves the start bits (bit 0 fast, bit 1 slow) and the mask bits unchanged, so the timers keep running.
- R8: Status bit 7 is the OR of the two flags, `irq_o` equals status bit 7, and bits 4..0 always read `ID_CODE`.
- R9: If an unmasked overflow and an interrupt-reset write take effect in the same clock, the overflow flag ends up set.
- R10: Clearing a start bit halts that timer, and no further overflow of it is flagged.
- R11: The sequence "fast preload 0xFF, control 0x21, wait more than one base tick" makes status read 0xC6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe, one clock per write |
| bus_port | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| status_o | output | 8 | Status byte returned on an index-port read |
| irq_o | output | 1 | Interrupt request, high while any flag is latched |

## Verification
Two functions can land in the same clock: a timer wrap that sets a flag, and an interrupt-reset write that clears it. The bench runs the fast timer with preload 0xFF, so it wraps on every base tick. It finds the clock in which the flag first rises, then places the reset write exactly one base tick later so that it lands on the next wrap. It then requires that the flag still reads set. A second reset write, placed away from any wrap, must read back as cleared, which shows that the write itself was accepted.

// File: rtl/fmtmr_pkg.sv
package fmtmr_pkg;
  localparam int NUM_TMR = 2;
  localparam int REG_W   = 8;
  localparam logic [REG_W-1:0] IDX_PRE_FAST = 8'h02;
  localparam logic [REG_W-1:0] IDX_PRE_SLOW = 8'h03;
  localparam logic [REG_W-1:0] IDX_CTRL     = 8'h04;
  // control bit positions
  localparam int CB_CLR       = 7;
  localparam int CB_MASK_FAST = 6;
  localparam int CB_MASK_SLOW = 5;
  localparam int CB_RUN_SLOW  = 1;
  localparam int CB_RUN_FAST  = 0;
  localparam int ID_W = 5;
endpackage

// File: rtl/fmtmr_prescale.sv
module fmtmr_prescale #(
  parameter int TICK_CYCLES = 16,
  parameter int SLOW_DIV    = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_fast,
  output logic tick_slow
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(TICK_CYCLES - 1);
  localparam logic [DW-1:0] D_LAST = DW'(SLOW_DIV - 1);

  logic [CW-1:0] base_q;
  logic [DW-1:0] div_q;

  assign tick_fast = (base_q == C_LAST);
  assign tick_slow = tick_fast && (div_q == D_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (tick_fast) begin
      base_q <= '0;
    end else begin
      base_q <= base_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (tick_slow) begin
      div_q <= '0;
    end else if (tick_fast) begin
      div_q <= div_q + 1'b1;
    end
  end

  // R4: a slow tick is always also a fast tick
  assert_slow_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |-> tick_fast);
  // R3: base ticks are spaced by the full prescale count
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fast |=> (base_q == '0));
endmodule

// File: rtl/fmtmr_counter.sv
module fmtmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] preload,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] cnt_q;

  assign ovf = run && tick && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= preload;
    end else if (tick) begin
      if (cnt_q == TOP) cnt_q <= preload;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: a running counter steps by one per tick below the top value
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R5: after a wrap the count restarts from the preload
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == $past(preload)));
  // R10: a halted counter does not move away from the preload
  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $stable(preload)) |=> (!run || cnt_q == $past(preload)));
endmodule

// File: rtl/fmtmr_regs.sv
module fmtmr_regs
  import fmtmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic                bus_port,
  input  logic [REG_W-1:0]    bus_wdata,
  input  logic [NUM_TMR-1:0]  ovf,
  output logic [REG_W-1:0]    preload [NUM_TMR],
  output logic [NUM_TMR-1:0]  run,
  output logic [NUM_TMR-1:0]  flag
);
  logic [REG_W-1:0]   idx_q;
  logic [NUM_TMR-1:0] run_q, mask_q, flag_q;
  logic               data_wr, ctrl_wr, clr_cmd;

  assign data_wr = bus_we && bus_port;
  assign ctrl_wr = data_wr && (idx_q == IDX_CTRL);
  assign clr_cmd = ctrl_wr && bus_wdata[CB_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (bus_we && !bus_port) begin
      idx_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload[0] <= '0;
      preload[1] <= '0;
    end else if (data_wr) begin
      if (idx_q == IDX_PRE_FAST) preload[0] <= bus_wdata;
      if (idx_q == IDX_PRE_SLOW) preload[1] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      mask_q <= '0;
    end else if (ctrl_wr && !bus_wdata[CB_CLR]) begin
      run_q  <= {bus_wdata[CB_RUN_SLOW], bus_wdata[CB_RUN_FAST]};
      mask_q <= {bus_wdata[CB_MASK_SLOW], bus_wdata[CB_MASK_FAST]};
    end
  end

  // an unmasked wrap in the clearing clock survives the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q & {NUM_TMR{!clr_cmd}}) | (ovf & ~mask_q);
    end
  end

  assign run  = run_q;
  assign flag = flag_q;

  // R6: a masked timer with a clear flag keeps it clear
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[0] && !flag_q[0]) |=> !flag_q[0]);
  assert_mask_blocks_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[1] && !flag_q[1]) |=> !flag_q[1]);
  // R7: clear without a concurrent wrap empties both flags
  assert_clear_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && ovf == '0) |=> (flag_q == '0));
  // R7: clear leaves run and mask state alone
  assert_clear_keeps_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> ($stable(run_q) && $stable(mask_q)));
  // R9: an unmasked wrap always shows up as a set flag
  assert_overflow_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[0] && !mask_q[0]) |=> flag_q[0]);
endmodule

// File: rtl/fmtmr_unit.sv
module fmtmr_unit
  import fmtmr_pkg::*;
#(
  parameter int              TICK_CYCLES = 16,
  parameter int              SLOW_DIV    = 4,
  parameter logic [ID_W-1:0] ID_CODE     = 5'h06
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_port,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] status_o,
  output logic             irq_o
);
  logic [NUM_TMR-1:0] tick, run, ovf, flag;
  logic [REG_W-1:0]   preload [NUM_TMR];
  logic               tick_fast, tick_slow;

  fmtmr_prescale #(.TICK_CYCLES(TICK_CYCLES), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow));

  assign tick = {tick_slow, tick_fast};

  fmtmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .ovf(ovf), .preload(preload), .run(run), .flag(flag));

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    fmtmr_counter #(.W(REG_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run[g]), .tick(tick[g]),
      .preload(preload[g]), .ovf(ovf[g]));
  end

  assign status_o = {(flag[0] | flag[1]), flag[0], flag[1], ID_CODE};
  assign irq_o    = status_o[7];

  // R8: an asserted interrupt always has a latched timer flag behind it
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o[6] || status_o[5]));
  // R3: the fast flag only rises after a fast-timer wrap
  assert_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> $past(ovf[0]));
endmodule

// File: tb/fmtmr_unit_tb.sv
module fmtmr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 16;
  localparam int SDIV = 4;
  localparam logic [4:0] ID = 5'h06;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic bus_port = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] status_o;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmtmr_unit #(.TICK_CYCLES(TICK), .SLOW_DIV(SDIV), .ID_CODE(ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .status_o(status_o), .irq_o(irq_o));

  function automatic logic [7:0] exp_status(input bit f_fast, input bit f_slow);
    return {f_fast | f_slow, f_fast, f_slow, ID};
  endfunction
  function automatic int lat_min(input int p, input int per);
    return (256 - p - 1) * per + 1;
  endfunction
  function automatic int lat_max(input int p, input int per);
    return (256 - p) * per;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input bit port, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_port = port; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] v);
    bus_write(1'b0, idx);
    bus_write(1'b1, v);
  endtask

  task automatic wait_bit(input int pos, output int j);
    j = 0;
    while (!status_o[pos] && j < LIMIT) begin
      @(negedge clk);
      j++;
    end
  endtask

  task automatic idle_clear();
    wr_reg(8'h04, 8'h60);
    wr_reg(8'h04, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int j, p, n;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status_o == 8'h06, "R1 status after reset", status_o, 8'h06);
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);

    // R11 presence sequence
    idle_clear();
    check(status_o == exp_status(0, 0), "R11 status cleared", status_o, exp_status(0, 0));
    wr_reg(8'h02, 8'hFF);
    wr_reg(8'h04, 8'h21);
    repeat (2 * TICK) @(negedge clk);
    check(status_o == 8'hC6, "R11 detection status", status_o, 8'hC6);
    check(irq_o == 1'b1, "R8 irq follows bit 7", irq_o, 1);
    idle_clear();
    check(status_o == 8'h06, "R7 clear after detection", status_o, 8'h06);

    // R3 fast timer latency, random preloads and the longest one
    for (int k = 0; k < 5; k++) begin
      p = (k == 0) ? 0 : $urandom_range(255, 192);
      idle_clear();
      wr_reg(8'h02, p[7:0]);
      wr_reg(8'h04, 8'h21);
      wait_bit(6, j);
      check(j >= lat_min(p, TICK) && j <= lat_max(p, TICK), "R3 fast latency", j, lat_max(p, TICK));
      check(status_o == exp_status(1, 0), "R8 status with fast flag", status_o, exp_status(1, 0));
    end

    // R4 slow timer latency
    for (int k = 0; k < 3; k++) begin
      p = $urandom_range(255, 240);
      idle_clear();
      wr_reg(8'h03, p[7:0]);
      wr_reg(8'h04, 8'h42);
      wait_bit(5, j);
      check(j >= lat_min(p, TICK * SDIV) && j <= lat_max(p, TICK * SDIV), "R4 slow latency",
            j, lat_max(p, TICK * SDIV));
      check(status_o == exp_status(0, 1), "R8 status with slow flag", status_o, exp_status(0, 1));
    end

    // R5 reload period, R7 clear keeps timer running
    for (int k = 0; k < 3; k++) begin
      p = $urandom_range(255, 224);
      n = 256 - p;
      idle_clear();
      wr_reg(8'h02, p[7:0]);
      wr_reg(8'h04, 8'h21);
      wait_bit(6, j);
      bus_we = 1'b1; bus_port = 1'b1; bus_wdata = 8'h80;
      @(negedge clk);
      bus_we = 1'b0;
      j = 1;
      check(status_o == 8'h06, "R7 clear while running", status_o, 8'h06);
      while (!status_o[6] && j < LIMIT) begin
        @(negedge clk);
        j++;
      end
      check(j == n * TICK, "R5 overflow period", j, n * TICK);
    end

    // R6 masked timers stay silent while running
    idle_clear();
    wr_reg(8'h02, 8'hFF);
    wr_reg(8'h03, 8'hFF);
    wr_reg(8'h04, 8'h63);
    repeat (5 * TICK * SDIV) @(negedge clk);
    check(status_o == 8'h06, "R6 masked no flag", status_o, 8'h06);
    check(irq_o == 1'b0, "R6 masked no irq", irq_o, 0);
    wr_reg(8'h04, 8'h03);
    repeat (3 * TICK * SDIV) @(negedge clk);
    check(status_o == exp_status(1, 1), "R8 both flags", status_o, exp_status(1, 1));

    // R10 stopped timers never flag
    idle_clear();
    wr_reg(8'h04, 8'h00);
    repeat (5 * TICK * SDIV) @(negedge clk);
    check(status_o == 8'h06, "R10 stopped no flag", status_o, 8'h06);

    // R2 unused index ignored, two-step addressing
    bus_write(1'b0, 8'h07);
    bus_write(1'b1, 8'h03);
    repeat (3 * TICK * SDIV) @(negedge clk);
    check(status_o == 8'h06, "R2 write to unused index", status_o, 8'h06);
    wr_reg(8'h02, 8'hFF);
    wr_reg(8'h05, 8'h00);
    wr_reg(8'h04, 8'h21);
    wait_bit(6, j);
    check(j >= 1 && j <= TICK, "R2 preload kept past unused index", j, TICK);

    // R9 overflow and clear in the same clock
    idle_clear();
    wr_reg(8'h02, 8'hFF);
    wr_reg(8'h04, 8'h21);
    wait_bit(6, j);
    repeat (TICK - 1) @(negedge clk);
    bus_we = 1'b1; bus_port = 1'b1; bus_wdata = 8'h80;
    @(negedge clk);
    bus_we = 1'b0;
    check(status_o[6] == 1'b1, "R9 overflow wins over clear", status_o[6], 1);
    bus_write(1'b1, 8'h80);
    check(status_o == 8'h06, "R7 clear off the wrap", status_o, 8'h06);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule